// File: doc/BRIEF.md
# Serial Boot and Clock Controller

This block lets a host computer bring up a small 8-bit processor over a single asynchronous serial line. Received bytes are decoded into commands that either set or clear one of eight individually addressable output pins, or load a byte-wide parallel output. Two of those pins have fixed meanings: one is the processor's active-low reset, the other chooses whether the processor clock runs freely or advances one pulse at a time on host command.

The block runs entirely from the communication oscillator (1.8432 MHz). With 16 oscillator cycles per bit the receive rate is 115200 baud. In free-running mode the processor clock is the oscillator divided by two. In single-step mode each step command produces exactly one clock pulse. Mode changes take effect only while the processor clock is low, so the processor never sees a shortened pulse.

Top module: `bootClockCtrl`

## Requirements
- R1: The receiver accepts 8N1 frames, least significant bit first, at 16 clock cycles per bit. It passes the input through two synchronizing flops and samples each bit near its middle.
- R2: A low level that has gone high again by the middle of the start bit is not taken as a start bit, and the receiver accepts a valid frame after it.
- R3: A frame whose stop bit is low pulses `rxFrameErr` high for one cycle, and its byte changes no output.
- R4: A byte with bit 7 at 0 writes bit 0 of the byte into the output pin that bits 3:1 select. Bits 6:4 are ignored and the other pins do not change.
- R5: A byte with bit 7 at 1 arms a load. The next byte, whatever its bit 7, is copied into `parOut` and is not decoded as a command.
- R6: After reset, `parOut` and `bitOut` are all zero, `cpuResetN` is low and `cpuClk` is low.
- R7: `cpuResetN` follows output pin 0.
- R8: While output pin 1 is 1, `cpuClk` alternates every clock cycle (half the oscillator frequency).
- R9: While output pin 1 is 0, a write of 1 to pin 2 gives exactly one `cpuClk` pulse, one cycle high. A write of 0 to pin 2 gives none.
- R10: `cpuClk` is never high for two cycles in a row, and a mode change takes effect only from a low phase.
- R11: A step command sent while free-running is dropped and gives no pulse after a return to single-step mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (1.8432 MHz) |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| rxIn | input | 1 | Asynchronous serial input, idle high |
| parOut | output | 8 | Byte-wide parallel output |
| bitOut | output | 8 | Addressable single-bit outputs |
| cpuResetN | output | 1 | Processor reset, active low |
| cpuClk | output | 1 | Processor clock |
| rxFrameErr | output | 1 | One-cycle pulse on a bad stop bit |

## Verification
A table of command bytes is sent through the serial input. It includes pin writes with junk in bits 6:4, clears, arm bytes, and data bytes whose bit 7 is set or clear. This shows that field decoding, the arm-then-load sequence and the isolation of unrelated pins each behave as specified. Directed frames follow: a short glitch and a frame with a low stop bit. These show that a false start is rejected and that a bad frame is dropped. The processor clock is watched through its run lengths and rising-edge counts across free-run, step, zero-writes and mode changes. These show that the divide ratio, the single pulse and the dropping of a step sent in free-run mode are each correct.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_SEL_W = 3;
  localparam int NUM_PINS  = 1 << BIT_SEL_W;
  localparam int RESET_IDX = 0;
  localparam int MODE_IDX  = 1;
  localparam int STEP_IDX  = 2;

  typedef struct packed {
    logic              bitWr;
    logic              parLoad;
    logic [DATA_W-1:0] data;
  } cmdStrobe_t;
endpackage

// File: rtl/bcc_uart_rx.sv
module bcc_uart_rx #(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFrameErr
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  logic              syncA, syncB;
  rxState_t          state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= rxIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitIdx     <= '0;
      shiftReg   <= '0;
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
    end else begin
      rxValid    <= 1'b0;
      rxFrameErr <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (!syncB) state <= ST_START;
        end
        ST_START: begin
          if (cnt == HALF_M1) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= syncB ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == FULL_M1) begin
            cnt      <= '0;
            shiftReg <= {syncB, shiftReg[DATA_W-1:1]};
            if (bitIdx == LAST_IDX) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == FULL_M1) begin
            cnt        <= '0;
            rxValid    <= syncB;
            rxFrameErr <= !syncB;
            state      <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign rxData = shiftReg;

  AST_NO_VALID_AND_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxFrameErr)); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid); // R1
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |=> !rxFrameErr); // R3
endmodule

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output cmdStrobe_t        strb
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      strb  <= '0;
    end else begin
      strb.bitWr   <= 1'b0;
      strb.parLoad <= 1'b0;
      if (rxValid) begin
        strb.data <= rxData;
        if (armed) begin
          strb.parLoad <= 1'b1;
          armed        <= 1'b0;
        end else if (rxData[DATA_W-1]) begin
          armed <= 1'b1;
        end else begin
          strb.bitWr <= 1'b1;
        end
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.bitWr && strb.parLoad)); // R5
  AST_LOAD_AFTER_ARM: assert property (@(posedge clk) disable iff (!rstN)
    strb.parLoad |-> !armed); // R5
endmodule

// File: rtl/bcc_datapath.sv
module bcc_datapath
  import bcc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  cmdStrobe_t          strb,
  output logic [DATA_W-1:0]   parOut,
  output logic [NUM_PINS-1:0] bitOut,
  output logic                cpuClk
);
  logic [NUM_PINS-1:0]  pinReg;
  logic [DATA_W-1:0]    parReg;
  logic                 stepPending;
  logic [BIT_SEL_W-1:0] sel;
  logic                 stepReq;
  logic                 freeReq;

  assign sel     = strb.data[BIT_SEL_W:1];
  assign freeReq = pinReg[MODE_IDX];
  assign stepReq = strb.bitWr && (sel == BIT_SEL_W'(STEP_IDX)) && strb.data[0] && !freeReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinReg <= '0;
      parReg <= '0;
    end else begin
      if (strb.bitWr) pinReg[sel] <= strb.data[0];
      if (strb.parLoad) parReg <= strb.data;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuClk      <= 1'b0;
      stepPending <= 1'b0;
    end else begin
      if (cpuClk) begin
        cpuClk <= 1'b0;
        if (stepReq) stepPending <= 1'b1;
      end else if (freeReq) begin
        cpuClk      <= 1'b1;
        stepPending <= 1'b0;
      end else if (stepPending) begin
        cpuClk      <= 1'b1;
        stepPending <= 1'b0;
      end else if (stepReq) begin
        stepPending <= 1'b1;
      end
    end
  end

  assign parOut = parReg;
  assign bitOut = pinReg;

  AST_CLK_HIGH_ONE: assert property (@(posedge clk) disable iff (!rstN)
    cpuClk |=> !cpuClk); // R10
  AST_FREE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClk && freeReq) |=> cpuClk); // R8
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.parLoad |=> $stable(parReg)); // R5
  AST_ONE_PIN: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(pinReg ^ $past(pinReg)) <= 1); // R4
  AST_STEP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuClk) && !$past(freeReq)) |-> $past(stepPending)); // R9
endmodule

// File: rtl/bootClockCtrl.sv
module bootClockCtrl
  import bcc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  output logic [DATA_W-1:0]   parOut,
  output logic [NUM_PINS-1:0] bitOut,
  output logic                cpuResetN,
  output logic                cpuClk,
  output logic                rxFrameErr
);
  logic              rxValid;
  logic [DATA_W-1:0] rxData;
  cmdStrobe_t        strb;

  bcc_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) uRx (
    .clk(clk), .rstN(rstN), .rxIn(rxIn),
    .rxValid(rxValid), .rxData(rxData), .rxFrameErr(rxFrameErr)
  );

  bcc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .strb(strb)
  );

  bcc_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .parOut(parOut), .bitOut(bitOut), .cpuClk(cpuClk)
  );

  assign cpuResetN = bitOut[RESET_IDX];

  AST_RESET_PIN: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetN == bitOut[RESET_IDX]); // R7
endmodule

// File: tb/bootClockCtrl_test.sv
`timescale 1ns/1ps
module bootClockCtrl_test;
  localparam int CPB = 16;
  localparam int NVEC = 12;
  // {command byte, expected bitOut, expected parOut}
  localparam logic [23:0] VECS [NVEC] = '{
    {8'h01, 8'h01, 8'h00},
    {8'h07, 8'h09, 8'h00},
    {8'h7F, 8'h89, 8'h00},
    {8'h0E, 8'h09, 8'h00},
    {8'h80, 8'h09, 8'h00},
    {8'hA5, 8'h09, 8'hA5},
    {8'hFF, 8'h09, 8'hA5},
    {8'h0F, 8'h09, 8'h0F},
    {8'h00, 8'h08, 8'h0F},
    {8'h0B, 8'h28, 8'h0F},
    {8'h80, 8'h28, 8'h0F},
    {8'h80, 8'h28, 8'h80}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic [7:0] parOut, bitOut;
  logic cpuResetN, cpuClk, rxFrameErr;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int hiViol = 0;
  int errPulses = 0;
  logic prevClk = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bootClockCtrl uut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .parOut(parOut), .bitOut(bitOut),
    .cpuResetN(cpuResetN), .cpuClk(cpuClk), .rxFrameErr(rxFrameErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (cpuClk && !prevClk) rises++;
      if (cpuClk && prevClk) hiViol++;
      if (rxFrameErr) errPulses++;
    end
    prevClk = cpuClk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic v, input int n);
    @(posedge clk); #1 rxIn = v;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopV);
    driveBit(1'b0, CPB);
    for (int i = 0; i < 8; i++) driveBit(b[i], CPB);
    if (stopV) driveBit(1'b1, CPB);
    else driveBit(1'b0, 12);
    driveBit(1'b1, 20);
    @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendFrame(b, 1'b1);
  endtask

  initial begin
    int r0;
    repeat (4) @(negedge clk);
    check("R6 parOut", parOut, 0);
    check("R6 bitOut", bitOut, 0);
    check("R6 cpuResetN", cpuResetN, 0);
    check("R6 cpuClk", cpuClk, 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R6 no clock after reset", rises, 0);

    // table of commands: R1 R4 R5 R7
    for (int i = 0; i < NVEC; i++) begin
      sendByte(VECS[i][23:16]);
      check("R4/R5 bitOut", bitOut, VECS[i][15:8]);
      check("R5 parOut", parOut, VECS[i][7:0]);
      check("R7 cpuResetN", cpuResetN, VECS[i][8]);
    end

    // R2 false start glitch then valid frame
    driveBit(1'b0, 5);
    driveBit(1'b1, 40);
    sendByte(8'h0D); // pin 6 = 1
    check("R2 frame after glitch", bitOut, 8'h68);

    // R3 framing error: byte would set pin 4
    sendFrame(8'h09, 1'b0);
    driveBit(1'b1, 30);
    @(negedge clk);
    check("R3 error pulse count", errPulses, 1);
    check("R3 byte dropped", bitOut, 8'h68);
    check("R3 parOut kept", parOut, 8'h80);

    // R9 single-step
    r0 = rises;
    sendByte(8'h05);
    repeat (10) @(negedge clk);
    check("R9 one pulse", rises - r0, 1);
    r0 = rises;
    sendByte(8'h04);
    repeat (10) @(negedge clk);
    check("R9 zero write no pulse", rises - r0, 0);
    r0 = rises;
    sendByte(8'h05);
    repeat (10) @(negedge clk);
    check("R9 repeat pulse", rises - r0, 1);

    // R8 free-run
    sendByte(8'h03);
    r0 = rises;
    repeat (20) @(negedge clk);
    check("R8 free-run rate", rises - r0, 10);

    // R11 step while free-running is dropped
    sendByte(8'h05);
    sendByte(8'h02);
    repeat (4) @(negedge clk);
    r0 = rises;
    repeat (30) @(negedge clk);
    check("R11 no stale pulse", rises - r0, 0);
    check("R10 stopped low", cpuClk, 0);
    check("R10 high never doubled", hiViol, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule